// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block is a byte-wide configuration register file of 256 eight-bit slots, reached through a two-location I/O window. A write to location 0 of the window loads an index pointer; an access to location 1 reads or writes the slot that the pointer selects. Slot 0 is not a storage slot: its place is taken by the index pointer itself, so a data read while the pointer is 0 always returns zero.

Most slots are read-only and hold zero. Writes to those slots are dropped without any indication. Six slots come out of reset with defined contents: an identification byte, a function-select byte that leaves every peripheral disabled, and four peripheral base-address bytes. The function-select byte and the four base bytes are brought out as live outputs so that neighbouring decode logic can use them.

The window answers only while an external enable input is high. A host-side configuration bit normally drives that input, and it is low after reset. While the window is off, reads return all ones and writes change nothing. Every access is a single byte, given by one-cycle strobes. Read data is registered, is valid in the cycle after the read strobe, and holds until the next accepted read.

Top module: `cfgp_window_top`

## Requirements
- R1: While `rst` is high, and after it falls, the index pointer is 0, `rd_data` is 0x00 and every slot is 0x00 except these: slot 0xE0 = 0x3C (identification), slot 0xE2 = 0x03 (function select, all functions off), slot 0xE3 = 0xFC (floppy base), slot 0xE6 = 0xDE (parallel base), slot 0xE7 = 0xFE (first serial base) and slot 0xE8 = 0xBE (second serial base).
- R2: A write strobe with `acc_sel` = 0 and `win_en` high loads `wr_data` into the index pointer and changes no slot.
- R3: A read strobe with `acc_sel` = 0 and `win_en` high makes `rd_data` equal to the index pointer one cycle later.
- R4: A read strobe with `acc_sel` = 1 and `win_en` high makes `rd_data` equal to the selected slot one cycle later. While the pointer is 0x00 the value read is always 0x00.
- R5: A write with `acc_sel` = 1 is dropped when the pointer is in 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R6: A write with `acc_sel` = 1 and `win_en` high, with the pointer at any other index, stores `wr_data` in that slot.
- R7: While `win_en` is low, a read strobe makes `rd_data` 0xFF one cycle later, and a write strobe changes neither the pointer nor any slot.
- R8: `rd_data` keeps its value in every cycle after one in which `acc_rd` was low.
- R9: `fsel_q`, `fdc_base`, `lpt_base`, `com1_base` and `com2_base` always show the current contents of slots 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8.
- R10: When `acc_wr` and `acc_rd` are both high in the same cycle, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_en | input | 1 | Window enable from host-side configuration |
| acc_sel | input | 1 | Window location: 0 = index pointer, 1 = data slot |
| acc_wr | input | 1 | One-cycle write strobe |
| acc_rd | input | 1 | One-cycle read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| fsel_q | output | 8 | Function-select slot 0xE2 |
| fdc_base | output | 8 | Floppy base slot 0xE3 |
| lpt_base | output | 8 | Parallel base slot 0xE6 |
| com1_base | output | 8 | First serial base slot 0xE7 |
| com2_base | output | 8 | Second serial base slot 0xE8 |

## Verification
The main function is exercised in three ways. A short scripted sequence mixes pointer loads, pointer read-backs and data accesses on writable and protected slots. A full sweep over all 256 indices writes a pattern derived from each index and reads it back, which separates the writable slots from the protected ones at every boundary of the protected ranges. A sequence with the window disabled checks that reads return 0xFF, and a read-back of the pointer afterwards shows that neither it nor any slot was touched. Directed cases cover the reset contents, the zero returned for slot 0, holding of the read data over idle cycles and writes, a simultaneous read and write, and a second reset that restores the defaults after they have been overwritten.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int CFG_DW    = 8;
    localparam int CFG_SLOTS = 1 << CFG_DW;

    localparam logic [CFG_DW-1:0] SLOT_IDENT = 8'hE0;
    localparam logic [CFG_DW-1:0] SLOT_FSEL  = 8'hE2;
    localparam logic [CFG_DW-1:0] SLOT_FDC   = 8'hE3;
    localparam logic [CFG_DW-1:0] SLOT_LPT   = 8'hE6;
    localparam logic [CFG_DW-1:0] SLOT_COM1  = 8'hE7;
    localparam logic [CFG_DW-1:0] SLOT_COM2  = 8'hE8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_IDX_WR,
        OP_DAT_WR,
        OP_IDX_RD,
        OP_DAT_RD,
        OP_OFF_RD
    } cfg_op_e;

    typedef struct packed {
        cfg_op_e           op;
        logic [CFG_DW-1:0] data;
    } cfg_cmd_t;

    // Protected slots: data writes to these never land.
    function automatic logic slot_locked(input logic [CFG_DW-1:0] s);
        return s inside {[8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED],
                         8'hF3, 8'hF5, 8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]};
    endfunction

    // Contents a slot takes on while reset is held.
    function automatic logic [CFG_DW-1:0] slot_init(input logic [CFG_DW-1:0] s);
        logic [CFG_DW-1:0] v;
        case (s)
            SLOT_IDENT: v = 8'h3C;
            SLOT_FSEL:  v = 8'h03;
            SLOT_FDC:   v = 8'hFC;
            SLOT_LPT:   v = 8'hDE;
            SLOT_COM1:  v = 8'hFE;
            SLOT_COM2:  v = 8'hBE;
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int DW = CFG_DW
) (
    input  logic          win_en,
    input  logic          acc_sel,
    input  logic          acc_wr,
    input  logic          acc_rd,
    input  logic [DW-1:0] wr_data,
    output cfg_cmd_t      cmd
);

    always_comb begin
        cmd.data = wr_data;
        cmd.op   = OP_NONE;
        if (!win_en) begin
            if (acc_rd && !acc_wr)
                cmd.op = OP_OFF_RD;
        end else if (acc_wr) begin
            cmd.op = acc_sel ? OP_DAT_WR : OP_IDX_WR;
        end else if (acc_rd) begin
            cmd.op = acc_sel ? OP_DAT_RD : OP_IDX_RD;
        end
    end

endmodule

// File: rtl/cfgp_index.sv
module cfgp_index
    import cfgp_pkg::*;
#(
    parameter int DW = CFG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  cfg_cmd_t      cmd,
    output logic [DW-1:0] idx_q
);

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (cmd.op == OP_IDX_WR)
            idx_q <= cmd.data;
    end

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter int DW    = CFG_DW,
    parameter int SLOTS = CFG_SLOTS
) (
    input  logic               clk,
    input  logic               rst,
    input  cfg_cmd_t           cmd,
    input  logic [DW-1:0]      idx,
    output logic [SLOTS*DW-1:0] slots_flat
);

    logic wr_hit;
    assign wr_hit = (cmd.op == OP_DAT_WR);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam logic [DW-1:0] GI = g[DW-1:0];
        if (!slot_locked(GI)) begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= slot_init(GI);
                else if (wr_hit && idx == GI)
                    q <= cmd.data;
            end
            assign slots_flat[g*DW +: DW] = q;
        end else begin : g_ro
            assign slots_flat[g*DW +: DW] = slot_init(GI);
        end
    end

endmodule

// File: rtl/cfgp_rdport.sv
module cfgp_rdport
    import cfgp_pkg::*;
#(
    parameter int DW    = CFG_DW,
    parameter int SLOTS = CFG_SLOTS
) (
    input  logic                clk,
    input  logic                rst,
    input  cfg_op_e             op,
    input  logic [DW-1:0]       idx,
    input  logic [SLOTS*DW-1:0] slots_flat,
    output logic [DW-1:0]       rd_data
);

    logic [DW-1:0] sel_slot;
    assign sel_slot = (idx == '0) ? '0 : slots_flat[idx*DW +: DW];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            case (op)
                OP_IDX_RD: rd_data <= idx;
                OP_DAT_RD: rd_data <= sel_slot;
                OP_OFF_RD: rd_data <= '1;
                default:   rd_data <= rd_data;
            endcase
        end
    end

endmodule

// File: rtl/cfgp_window_top.sv
module cfgp_window_top
    import cfgp_pkg::*;
#(
    parameter int DATA_W = CFG_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_en,
    input  logic              acc_sel,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] fsel_q,
    output logic [DATA_W-1:0] fdc_base,
    output logic [DATA_W-1:0] lpt_base,
    output logic [DATA_W-1:0] com1_base,
    output logic [DATA_W-1:0] com2_base
);

    localparam int SLOTS = 1 << DATA_W;

    cfg_cmd_t                  cmd;
    logic [DATA_W-1:0]         idx_q;
    logic [SLOTS*DATA_W-1:0]   slots_flat;

    cfgp_decode #(.DW(DATA_W)) u_decode (
        .win_en  (win_en),
        .acc_sel (acc_sel),
        .acc_wr  (acc_wr),
        .acc_rd  (acc_rd),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    cfgp_index #(.DW(DATA_W)) u_index (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .idx_q (idx_q)
    );

    cfgp_regfile #(.DW(DATA_W), .SLOTS(SLOTS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .idx        (idx_q),
        .slots_flat (slots_flat)
    );

    cfgp_rdport #(.DW(DATA_W), .SLOTS(SLOTS)) u_rdport (
        .clk        (clk),
        .rst        (rst),
        .op         (cmd.op),
        .idx        (idx_q),
        .slots_flat (slots_flat),
        .rd_data    (rd_data)
    );

    assign fsel_q    = slots_flat[int'(SLOT_FSEL)*DATA_W +: DATA_W];
    assign fdc_base  = slots_flat[int'(SLOT_FDC)*DATA_W  +: DATA_W];
    assign lpt_base  = slots_flat[int'(SLOT_LPT)*DATA_W  +: DATA_W];
    assign com1_base = slots_flat[int'(SLOT_COM1)*DATA_W +: DATA_W];
    assign com2_base = slots_flat[int'(SLOT_COM2)*DATA_W +: DATA_W];

endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk
    import cfgp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       win_en,
    input logic       acc_sel,
    input logic       acc_wr,
    input logic       acc_rd,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] idx_q,
    input logic [39:0] outs
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (idx_q == 8'h00 && rd_data == 8'h00 && outs == 40'h03FCDEFEBE));

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (win_en && acc_wr && !acc_sel) |=> (idx_q == $past(wr_data) && $stable(outs)));

    // R3
    idx_read_chk: assert property (@(posedge clk) disable iff (rst)
        (win_en && acc_rd && !acc_wr && !acc_sel) |=> rd_data == $past(idx_q));

    // R4
    slot0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (win_en && acc_rd && !acc_wr && acc_sel && idx_q == 8'h00) |=> rd_data == 8'h00);

    // R5
    locked_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (win_en && acc_wr && acc_sel && slot_locked(idx_q)) |=> $stable(outs));

    // R7
    off_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!win_en && acc_rd && !acc_wr) |=> rd_data == 8'hFF);

    // R7
    off_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!win_en && acc_wr) |=> ($stable(idx_q) && $stable(outs)));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> $stable(rd_data));

    // R10
    wr_over_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_rd) |=> $stable(rd_data));

endmodule

bind cfgp_window_top cfgp_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .win_en  (win_en),
    .acc_sel (acc_sel),
    .acc_wr  (acc_wr),
    .acc_rd  (acc_rd),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .idx_q   (idx_q),
    .outs    ({fsel_q, fdc_base, lpt_base, com1_base, com2_base})
);

// File: tb/cfgp_window_top_tb_top.sv
`timescale 1ns/1ps
module cfgp_window_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       win_en = 1'b0, acc_sel = 1'b0, acc_wr = 1'b0, acc_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data, fsel_q, fdc_base, lpt_base, com1_base, com2_base;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cfgp_window_top dut_i (
        .clk(clk), .rst(rst), .win_en(win_en), .acc_sel(acc_sel),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .wr_data(wr_data), .rd_data(rd_data),
        .fsel_q(fsel_q), .fdc_base(fdc_base), .lpt_base(lpt_base),
        .com1_base(com1_base), .com2_base(com2_base)
    );

    // Protected set and reset contents, written from the requirements (R5, R1).
    function automatic bit tb_locked(input logic [7:0] s);
        return (s <= 8'hDF) || s == 8'hE4 || s == 8'hE5 || (s >= 8'hE9 && s <= 8'hED) ||
               s == 8'hF3 || s == 8'hF5 || s == 8'hF7 || (s >= 8'hF9 && s <= 8'hFB) ||
               s >= 8'hFD;
    endfunction

    function automatic logic [7:0] tb_init(input logic [7:0] s);
        case (s)
            8'hE0: return 8'h3C;
            8'hE2: return 8'h03;
            8'hE3: return 8'hFC;
            8'hE6: return 8'hDE;
            8'hE7: return 8'hFE;
            8'hE8: return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: strobes set at a falling edge, consumed by the next rising
    // edge, result visible at the following falling edge.
    task automatic acc(input logic en, input logic sel, input logic wr, input logic rd,
                       input logic [7:0] d);
        @(negedge clk);
        win_en = en; acc_sel = sel; acc_wr = wr; acc_rd = rd; wr_data = d;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; win_en = 1'b0; acc_wr = 1'b0; acc_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [39:0] outs();
        return {fsel_q, fdc_base, lpt_base, com1_base, com2_base};
    endfunction

    // Vector: {en, sel, wr, rd, wdata[7:0], expected rd_data[7:0]}
    localparam int NV = 18;
    localparam logic [19:0] VEC [NV] = '{
        {4'b1010, 8'hE2, 8'h00},   // point at function select
        {4'b1101, 8'h00, 8'h03},   // R4 reset value of E2
        {4'b1001, 8'h00, 8'hE2},   // R3 pointer read
        {4'b1110, 8'h55, 8'h00},   // R6 store into E2
        {4'b1101, 8'h00, 8'h55},   // R6 read back
        {4'b1010, 8'hE4, 8'h00},   // point at protected slot
        {4'b1110, 8'h77, 8'h00},   // R5 dropped
        {4'b1101, 8'h00, 8'h00},   // R5 still zero
        {4'b0010, 8'h00, 8'h00},   // R7 pointer write while off
        {4'b0101, 8'h00, 8'hFF},   // R7 read while off
        {4'b0110, 8'h11, 8'h00},   // R7 data write while off
        {4'b1001, 8'h00, 8'hE4},   // R7 pointer unchanged
        {4'b1010, 8'h00, 8'h00},   // pointer to slot 0
        {4'b1110, 8'h99, 8'h00},   // R5 slot 0 protected
        {4'b1101, 8'h00, 8'h00},   // R4 slot 0 reads zero
        {4'b1001, 8'h00, 8'h00},   // R2 pointer stays 0
        {4'b1010, 8'hE0, 8'h00},   // point at identification
        {4'b1101, 8'h00, 8'h3C}    // R4 identification
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold;
        do_reset();
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 rd_data", {32'h0, rd_data}, {32'h0, 8'h00});
        check("R1 outputs", outs(), 40'h03FCDEFEBE);
        acc(1, 0, 0, 1, 8'h00);
        check("R1 pointer", {32'h0, rd_data}, 40'h0);

        // Table walk: R2,R3,R4,R5,R6,R7
        for (int v = 0; v < NV; v++) begin
            acc(VEC[v][19], VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:8]);
            if (VEC[v][16])
                check($sformatf("vec %0d (R3,R4,R5,R6,R7)", v), {32'h0, rd_data}, {32'h0, VEC[v][7:0]});
        end
        check("R9 fsel after store", outs(), 40'h55FCDEFEBE);

        // R2 pointer write leaves slots alone
        acc(1, 0, 1, 0, 8'hE7);
        check("R2 slots unchanged", outs(), 40'h55FCDEFEBE);

        // R8 hold across idle cycles and writes
        acc(1, 1, 0, 1, 8'h00);
        hold = rd_data;
        check("R8 read E7", {32'h0, hold}, {32'h0, 8'hFE});
        repeat (4) @(negedge clk);
        acc(1, 1, 1, 0, 8'h42);
        check("R8 hold after write", {32'h0, rd_data}, {32'h0, hold});
        check("R9 com1 updated", {32'h0, com1_base}, {32'h0, 8'h42});

        // R10 simultaneous read and write: write done, read ignored
        acc(1, 1, 1, 1, 8'h24);
        check("R10 rd_data unchanged", {32'h0, rd_data}, {32'h0, hold});
        check("R10 write landed", {32'h0, com1_base}, {32'h0, 8'h24});

        // Second reset restores defaults (R1)
        do_reset();
        @(negedge clk);
        check("R1 defaults restored", outs(), 40'h03FCDEFEBE);

        // Full sweep: R4,R5,R6
        for (int i = 0; i < 256; i++) begin
            logic [7:0] pat, exp;
            pat = 8'(i) ^ 8'hA5;
            exp = (i == 0) ? 8'h00 : (tb_locked(8'(i)) ? tb_init(8'(i)) : pat);
            acc(1, 0, 1, 0, 8'(i));
            acc(1, 1, 1, 0, pat);
            acc(1, 1, 0, 1, 8'h00);
            check($sformatf("sweep slot %02h (R4,R5,R6)", i), {32'h0, rd_data}, {32'h0, exp});
        end
        check("R9 outputs after sweep", outs(),
              {8'hE2 ^ 8'hA5, 8'hE3 ^ 8'hA5, 8'hE6 ^ 8'hA5, 8'hE7 ^ 8'hA5, 8'hE8 ^ 8'hA5});

        // R7 disabled writes do not reach slots
        acc(1, 0, 1, 0, 8'hE2);
        acc(0, 1, 1, 0, 8'h00);
        acc(1, 1, 0, 1, 8'h00);
        check("R7 slot kept while off", {32'h0, rd_data}, {32'h0, 8'hE2 ^ 8'hA5});

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule